// File: doc/BRIEF.md
# Periodic Interrupt Timer Channel

A single periodic timeout channel built from two cascaded down counters. A micro-timer divides the bus clock and issues a one-cycle tick every (mtld_i + 1) clocks. A 16-bit main counter advances once per tick and reaches the end of its period after (ld_i + 1) ticks. The full period is therefore exactly (mtld_i + 1) * (ld_i + 1) bus clocks. Both load values of zero give a timeout on every clock. At a 2 MHz bus clock that is a 0.5 µs period, and loads of 0 and 1 give 1 µs.

The end of each period sets a sticky flag. The flag stays set until a clear pulse arrives, and it drives the interrupt output when the interrupt enable is high. While the enable is low, the channel keeps copying its load values into both counters, so a rising enable starts a full period from the top. A load value changed while the channel runs is picked up at the next reload of that stage.

Top module: `pit_chan`

## Requirements
- R1: During reset, cnt_o is 0, flag_o is 0 and irq_o is 0.
- R2: Taking the first enabled cycle as t = 0 with constant loads M = mtld_i and L = ld_i, the end of the period occurs in cycle t = P-1, where P = (M+1)*(L+1), and again every P cycles after that. From a cleared state, flag_o first reads 1 at t = P.
- R3: With M = 0, the end of the period occurs in every cycle t where (t+1) is a multiple of (L+1). With L = 0 this is every cycle. With L = 1, cnt_o reads 1 for one clock and then 0 for one clock.
- R4: While enabled, cnt_o at cycle t equals L - ((t mod P) div (M+1)). Each value from L down to 0 is held for M+1 clocks, and the counter reloads L after 0.
- R5: While en_i is low, flag_o is never set, and cnt_o shows the ld_i value from the previous clock.
- R6: flag_o stays set until clr_i is sampled high. A clr_i in a cycle with no end of period clears flag_o at the next clock. A clr_i in the same cycle as an end of period leaves flag_o set.
- R7: irq_o equals flag_o AND ie_i.
- R8: A change of ld_i while enabled leaves the current period unchanged. The new value is first loaded when the counter reloads after reaching 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| mtld_i | input | 8 | Micro-timer load value |
| ld_i | input | 16 | Main counter load value |
| ie_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Clear for the sticky timeout flag |
| cnt_o | output | 16 | Current main counter value |
| flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Random pairs of micro-timer and counter loads, including zeros, are compared cycle by cycle with a closed-form count and flag model. This separates a correct period of (M+1)*(L+1) clocks from versions that are off by one in either stage. One directed run holds clear high with a divider of 1. Its flag pattern shows whether the end of the period repeats every clock (L = 0) or every second clock (L = 1), and it also covers a clear arriving in the same cycle as an end of period. A further run changes the load value in the middle of a period, which separates loading at the next reload from loading at once. Runs with the channel disabled show that nothing sets the flag and that the counter only follows the load value.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned PIT_CNT_W = 16;
  localparam int unsigned PIT_MT_W  = 8;
endpackage

// File: rtl/pit_utick.sv
module pit_utick #(
  parameter int unsigned MW = pit_pkg::PIT_MT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [MW-1:0] mtld_i,
  output logic          tick_o
);
  logic [MW-1:0] mt_q;

  assign tick_o = en_i && (mt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mt_q <= '0;
    else if (!en_i || tick_o)  mt_q <= mtld_i;
    else                       mt_q <= mt_q - 1'b1;
  end

  // a nonzero divider never gives back-to-back ticks
  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (mtld_i != '0) |=> !tick_o);
endmodule

// File: rtl/pit_dcnt.sv
module pit_dcnt #(
  parameter int unsigned CW = pit_pkg::PIT_CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] ld_i,
  output logic [CW-1:0] cnt_o,
  output logic          to_o
);
  logic [CW-1:0] cnt_q;

  assign to_o  = tick_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= ld_i;
    else if (tick_i) begin
      if (cnt_q == '0)  cnt_q <= ld_i;
      else              cnt_q <= cnt_q - 1'b1;
    end
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(cnt_q));

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pit_flag.sv
module pit_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic to_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  assign flag_o = flag_q;

  // a new timeout wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= to_i | (flag_q & ~clr_i);
  end

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_i |=> flag_q);

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !to_i |=> !flag_q);
endmodule

// File: rtl/pit_chan.sv
module pit_chan #(
  parameter int unsigned CW = pit_pkg::PIT_CNT_W,
  parameter int unsigned MW = pit_pkg::PIT_MT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [MW-1:0] mtld_i,
  input  logic [CW-1:0] ld_i,
  input  logic          ie_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic tick;
  logic to;

  pit_utick #(.MW(MW)) u_utick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mtld_i(mtld_i), .tick_o(tick)
  );

  pit_dcnt #(.CW(CW)) u_dcnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .ld_i(ld_i),
    .cnt_o(cnt_o), .to_o(to)
  );

  pit_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .to_i(to), .clr_i(clr_i), .flag_o(flag_o)
  );

  assign irq_o = flag_o & ie_i;

  p_quiet_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !flag_o |=> !flag_o);

  p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !irq_o);
endmodule

// File: tb/sim_pit_chan.sv
`timescale 1ns/1ps
module sim_pit_chan;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  mtld_i = '0;
  logic [15:0] ld_i = '0;
  logic        ie_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [15:0] cnt_o;
  logic        flag_o;
  logic        irq_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  pit_chan u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(int m, int l, int t);
    int p = (m + 1) * (l + 1);
    return l - ((t % p) / (m + 1));
  endfunction

  task automatic run_case(string req, int m, int l, bit ie, int n);
    int p = (m + 1) * (l + 1);
    @(negedge clk_i);
    en_i = 0; mtld_i = 8'(m); ld_i = 16'(l); ie_i = ie; clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    @(negedge clk_i);
    check("R5 load while off", cnt_o, l);
    check("R6 cleared", flag_o, 0);
    en_i = 1;
    for (int t = 0; t < n; t++) begin
      check({req, " cnt"}, cnt_o, exp_cnt(m, l, t));
      check({req, " flag"}, flag_o, int'(t >= p));
      check("R7 irq", irq_o, int'((t >= p) && ie));
      @(negedge clk_i);
    end
    en_i = 0;
    @(negedge clk_i);
    check("R6 sticky", flag_o, int'(n >= p));
    clr_i = 1;
    @(negedge clk_i);
    clr_i = 0;
    check("R6 clear", flag_o, 0);
  endtask

  // clear held high: flag shows only the cycle after each end of period
  task automatic run_clr(int m, int l, int n);
    int p = (m + 1) * (l + 1);
    @(negedge clk_i);
    en_i = 0; mtld_i = 8'(m); ld_i = 16'(l); clr_i = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    en_i = 1;
    for (int t = 0; t < n; t++) begin
      check("R3 R6 clr vs timeout", flag_o, int'(t >= p && (t % p) == 0));
      if (m == 0 && l == 1) check("R3 cnt", cnt_o, 1 - (t % 2));
      @(negedge clk_i);
    end
    en_i = 0; clr_i = 0;
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=0 exp=1");
      finish_up();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk_i);
    check("R1 cnt", cnt_o, 0);
    check("R1 flag", flag_o, 0);
    ie_i = 1;
    check("R1 irq", irq_o, 0);
    rst_ni = 1;

    // R5: disabled, zero loads, nothing sets the flag
    mtld_i = 0; ld_i = 0; clr_i = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      check("R5 no flag off", flag_o, 0);
    end
    ld_i = 16'd9;
    @(negedge clk_i);
    check("R5 follows ld", cnt_o, 9);

    // R3 directed
    run_case("R3", 0, 0, 1, 6);
    run_case("R3", 0, 1, 1, 8);
    run_clr(0, 0, 6);
    run_clr(0, 1, 9);
    run_clr(2, 1, 14);

    // R8: reload change mid-period
    @(negedge clk_i);
    en_i = 0; mtld_i = 1; ld_i = 3; clr_i = 1; ie_i = 0;
    @(negedge clk_i);
    clr_i = 0;
    @(negedge clk_i);
    en_i = 1;
    for (int t = 0; t < 16; t++) begin
      check("R8 cnt", cnt_o, (t < 8) ? 3 - t / 2 : 6 - (t - 8) / 2);
      check("R8 flag", flag_o, int'(t >= 8));
      if (t == 2) ld_i = 16'd6;
      @(negedge clk_i);
    end
    en_i = 0;

    // random loads
    for (int k = 0; k < 24; k++) begin
      int m, l, p;
      m = int'($urandom % 6);
      l = int'($urandom % 20);
      if (k == 0) l = 0;
      if (k == 1) m = 0;
      p = (m + 1) * (l + 1);
      run_case("R2 R4", m, l, bit'($urandom % 2), 3 * p + 2);
    end

    done = 1;
    finish_up();
  end
endmodule